// File: doc/BRIEF.md
# Road Matching Track Linker

The linker takes the fired-pixel vectors of four axial layers for one azimuthal slice and searches them for tracks. Each layer vector covers the slice plus its neighbouring pixels, because a curved track can cross the outer layers outside the slice. It then compares these inputs with a loadable table of roads. A road names one pixel in each of the four layers, and a track counts as found when all four of those pixels fired, or when three of them fired.

Per beam crossing the block reports a single best candidate. The outputs are a valid pulse, a found flag and the 12-bit track word stored with the winning road. The road table is filled through a simple write port before traffic starts. The table depth and the layer window width are parameters.

Top module: `road_linker`

## Requirements
- R1: After reset, trk_valid, trk_found and trk_word are all zero, and every road entry is invalid, so no crossing can report a track until roads are written.
- R2: A crossing presented with xing_valid high at clock edge E raises trk_valid for exactly the cycle after edge E+1. No crossing means trk_valid stays low.
- R3: A valid road whose four pixels all fired gives trk_found=1 and trk_word equal to that road's stored word.
- R4: A valid road with exactly three of its four pixels fired also matches, whichever layer is the missing one.
- R5: A road with two or fewer of its pixels fired does not match.
- R6: A four-layer match wins over any three-layer match, whatever their table positions.
- R7: Among matches of the same quality, the road with the lowest table index wins.
- R8: When no road matches, trk_found=0 and trk_word=0 during the valid pulse.
- R9: A road written with its valid bit clear never matches, even if all its pixels fired.
- R10: Writing with cfg_we=1 stores the entry at cfg_addr, replacing the old one. cfg_pix[l*5 +: 5] is the pixel index in layer l. Pixel p of layer l is pix_in[l*24 + p].
- R11: A pixel index of 24 or more is outside the window and counts as not fired.
- R12: trk_found and trk_word hold their values between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xing_valid | input | 1 | Marks a crossing's pixel data on pix_in |
| pix_in | input | 96 | Fired pixels, 24 per layer, layer 0 in the low bits |
| cfg_we | input | 1 | Road table write strobe |
| cfg_addr | input | 4 | Road table entry to write |
| cfg_pix | input | 20 | Four 5-bit pixel indices, layer 0 in the low bits |
| cfg_word | input | 12 | Track word reported when this road wins |
| cfg_vld | input | 1 | Valid bit of the written entry |
| trk_valid | output | 1 | One-cycle pulse per evaluated crossing |
| trk_found | output | 1 | A road matched in this crossing |
| trk_word | output | 12 | Track word of the winning road, zero if none |

## Verification
The bench targets the ranking rules directly:
- A full-match road placed above a partial one catches a design that ranks by index alone; such a design would report the partial road.
- Two identical roads catch a picker that favours the highest index.
- Hit patterns that knock out each layer in turn catch a counter that requires one specific layer.
- Out-of-window indices catch a decoder that wraps into a neighbouring layer's bits; such a decoder would create false matches.
- Invalid entries and rewritten entries show whether stale table contents leak into the result.
- Random tables and hit patterns are then scored against a bench model of the priority rules.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  localparam int unsigned NLAYER = 4;
  localparam int unsigned TRKW   = 12;
  localparam int unsigned CNTW   = 3;

  // number of layers whose road pixel fired
  function automatic logic [CNTW-1:0] count_hits(input logic [NLAYER-1:0] h);
    logic [CNTW-1:0] c;
    c = '0;
    for (int i = 0; i < NLAYER; i++) begin
      c = c + {{(CNTW-1){1'b0}}, h[i]};
    end
    return c;
  endfunction
endpackage

// File: rtl/lnk_road_table.sv
module lnk_road_table
  import lnk_pkg::*;
#(
  parameter int unsigned NROADS = 16,
  parameter int unsigned IW     = 5,
  localparam int unsigned AW    = (NROADS > 1) ? $clog2(NROADS) : 1,
  localparam int unsigned EPW   = NLAYER * IW
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [EPW-1:0]           wr_pix,
  input  logic [TRKW-1:0]          wr_word,
  input  logic                     wr_vld,
  output logic [NROADS*EPW-1:0]    road_pix,
  output logic [NROADS*TRKW-1:0]   road_word,
  output logic [NROADS-1:0]        road_vld
);

  for (genvar r = 0; r < NROADS; r++) begin : g_ent
    logic            ent_we;
    logic [EPW-1:0]  pix_d,  pix_q;
    logic [TRKW-1:0] word_d, word_q;
    logic            vld_d,  vld_q;

    assign ent_we = wr_en && (wr_addr == AW'(r));

    always_comb begin
      pix_d  = pix_q;
      word_d = word_q;
      vld_d  = vld_q;
      if (ent_we) begin
        pix_d  = wr_pix;
        word_d = wr_word;
        vld_d  = wr_vld;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pix_q  <= '0;
        word_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        pix_q  <= pix_d;
        word_q <= word_d;
        vld_q  <= vld_d;
      end
    end

    assign road_pix[r*EPW +: EPW]    = pix_q;
    assign road_word[r*TRKW +: TRKW] = word_q;
    assign road_vld[r]               = vld_q;
  end

  AST_WR_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (road_vld[$past(wr_addr)] == $past(wr_vld))) else $error("write lost"); // R10

endmodule

// File: rtl/lnk_road_match.sv
module lnk_road_match
  import lnk_pkg::*;
#(
  parameter int unsigned NPIX   = 24,
  parameter int unsigned NROADS = 16,
  parameter int unsigned IW     = 5,
  localparam int unsigned PADW  = 1 << IW,
  localparam int unsigned EPW   = NLAYER * IW
)(
  input  logic [NLAYER*NPIX-1:0]   pix,
  input  logic [NROADS*EPW-1:0]    road_pix,
  input  logic [NROADS-1:0]        road_vld,
  output logic [NROADS-1:0]        full_hit,
  output logic [NROADS-1:0]        part_hit
);

  // zero-padded layer vectors: an index past the window reads a zero
  logic [PADW-1:0] lay_pad [NLAYER];
  for (genvar l = 0; l < NLAYER; l++) begin : g_pad
    assign lay_pad[l] = PADW'(pix[l*NPIX +: NPIX]);
  end

  for (genvar r = 0; r < NROADS; r++) begin : g_road
    logic [NLAYER-1:0] hit;
    logic [CNTW-1:0]   cnt;
    for (genvar l = 0; l < NLAYER; l++) begin : g_lay
      logic [IW-1:0] idx;
      assign idx    = road_pix[(r*NLAYER + l)*IW +: IW];
      assign hit[l] = lay_pad[l][idx];
    end
    assign cnt         = count_hits(hit);
    assign full_hit[r] = road_vld[r] && (cnt == CNTW'(NLAYER));
    assign part_hit[r] = road_vld[r] && (cnt >= CNTW'(NLAYER - 1));
  end

endmodule

// File: rtl/lnk_best_select.sv
module lnk_best_select
  import lnk_pkg::*;
#(
  parameter int unsigned NROADS = 16
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    eval_en,
  input  logic [NROADS-1:0]       full_hit,
  input  logic [NROADS-1:0]       part_hit,
  input  logic [NROADS*TRKW-1:0]  road_word,
  output logic                    trk_valid,
  output logic                    trk_found,
  output logic [TRKW-1:0]         trk_word
);

  logic [NROADS-1:0] cand;
  logic [NROADS-1:0] grant;
  logic [TRKW-1:0]   word_mux;
  logic              valid_d, found_d;
  logic [TRKW-1:0]   word_d;

  // full matches outrank partial ones; lowest index wins inside a class
  always_comb begin
    logic seen;
    cand     = (|full_hit) ? full_hit : part_hit;
    seen     = 1'b0;
    word_mux = '0;
    for (int r = 0; r < NROADS; r++) begin
      grant[r] = cand[r] && !seen;
      seen     = seen || cand[r];
      if (grant[r]) word_mux = word_mux | road_word[r*TRKW +: TRKW];
    end
  end

  always_comb begin
    valid_d = eval_en;
    found_d = trk_found;
    word_d  = trk_word;
    if (eval_en) begin
      found_d = |cand;
      word_d  = word_mux;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_valid <= 1'b0;
      trk_found <= 1'b0;
      trk_word  <= '0;
    end else begin
      trk_valid <= valid_d;
      trk_found <= found_d;
      trk_word  <= word_d;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)) else $error("multiple winners"); // R7
  AST_NOMATCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_valid && !trk_found) |-> (trk_word == '0)) else $error("word without track"); // R8
  AST_PART_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && (|part_hit)) |=> (trk_valid && trk_found)) else $error("match dropped"); // R4
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !trk_valid |-> ($stable(trk_word) && $stable(trk_found))) else $error("result moved"); // R12

endmodule

// File: rtl/road_linker.sv
module road_linker
  import lnk_pkg::*;
#(
  parameter int unsigned NPIX   = 24,
  parameter int unsigned NROADS = 16,
  localparam int unsigned IW    = $clog2(NPIX),
  localparam int unsigned AW    = (NROADS > 1) ? $clog2(NROADS) : 1,
  localparam int unsigned EPW   = NLAYER * IW,
  localparam int unsigned PXW   = NLAYER * NPIX
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xing_valid,
  input  logic [PXW-1:0]    pix_in,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [EPW-1:0]    cfg_pix,
  input  logic [TRKW-1:0]   cfg_word,
  input  logic              cfg_vld,
  output logic              trk_valid,
  output logic              trk_found,
  output logic [TRKW-1:0]   trk_word
);

  logic [PXW-1:0]          pix_d, pix_q;
  logic                    eval_d, eval_q;
  logic [NROADS*EPW-1:0]   road_pix;
  logic [NROADS*TRKW-1:0]  road_word;
  logic [NROADS-1:0]       road_vld;
  logic [NROADS-1:0]       full_hit, part_hit;

  // capture stage: pixels load only on a crossing
  always_comb begin
    eval_d = xing_valid;
    pix_d  = pix_q;
    if (xing_valid) pix_d = pix_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= '0;
      eval_q <= 1'b0;
    end else begin
      pix_q  <= pix_d;
      eval_q <= eval_d;
    end
  end

  lnk_road_table #(.NROADS(NROADS), .IW(IW)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_addr   (cfg_addr),
    .wr_pix    (cfg_pix),
    .wr_word   (cfg_word),
    .wr_vld    (cfg_vld),
    .road_pix  (road_pix),
    .road_word (road_word),
    .road_vld  (road_vld)
  );

  lnk_road_match #(.NPIX(NPIX), .NROADS(NROADS), .IW(IW)) u_match (
    .pix      (pix_q),
    .road_pix (road_pix),
    .road_vld (road_vld),
    .full_hit (full_hit),
    .part_hit (part_hit)
  );

  lnk_best_select #(.NROADS(NROADS)) u_select (
    .clk       (clk),
    .rst_n     (rst_n),
    .eval_en   (eval_q),
    .full_hit  (full_hit),
    .part_hit  (part_hit),
    .road_word (road_word),
    .trk_valid (trk_valid),
    .trk_found (trk_found),
    .trk_word  (trk_word)
  );

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    trk_valid |-> $past(xing_valid, 2)) else $error("stray valid"); // R2
  AST_INVALID_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_q && !(|road_vld)) |=> !trk_found) else $error("empty table found track"); // R9

endmodule

// File: tb/tb_road_linker.sv
module tb_road_linker;
  localparam int NPIX = 24;
  localparam int NR   = 16;
  localparam int IW   = 5;
  localparam int PXW  = 4 * NPIX;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            xing_valid;
  logic [PXW-1:0]  pix_in;
  logic            cfg_we;
  logic [3:0]      cfg_addr;
  logic [19:0]     cfg_pix;
  logic [11:0]     cfg_word;
  logic            cfg_vld;
  logic            trk_valid, trk_found;
  logic [11:0]     trk_word;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int         m_pix [NR][4];
  logic [11:0] m_word [NR];
  bit          m_vld [NR];

  always #2.5 clk = ~clk;

  road_linker #(.NPIX(NPIX), .NROADS(NR)) dut (
    .clk(clk), .rst_n(rst_n), .xing_valid(xing_valid), .pix_in(pix_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_pix(cfg_pix), .cfg_word(cfg_word),
    .cfg_vld(cfg_vld), .trk_valid(trk_valid), .trk_found(trk_found), .trk_word(trk_word)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [PXW-1:0] p, output logic f, output logic [11:0] w);
    int b4 = -1, b3 = -1;
    for (int r = 0; r < NR; r++) begin
      if (m_vld[r]) begin
        int c = 0;
        for (int l = 0; l < 4; l++)
          if (m_pix[r][l] < NPIX && p[l*NPIX + m_pix[r][l]]) c++;
        if (c == 4 && b4 < 0) b4 = r;
        if (c >= 3 && b3 < 0) b3 = r;
      end
    end
    if (b4 >= 0)      begin f = 1'b1; w = m_word[b4]; end
    else if (b3 >= 0) begin f = 1'b1; w = m_word[b3]; end
    else              begin f = 1'b0; w = '0; end
  endfunction

  task automatic load(int a, int p0, int p1, int p2, int p3, logic [11:0] w, bit v);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_addr = 4'(a);
    cfg_pix  = {5'(p3), 5'(p2), 5'(p1), 5'(p0)};
    cfg_word = w;
    cfg_vld  = v;
    @(negedge clk);
    cfg_we = 1'b0;
    m_pix[a][0] = p0; m_pix[a][1] = p1; m_pix[a][2] = p2; m_pix[a][3] = p3;
    m_word[a] = w; m_vld[a] = v;
  endtask

  function automatic logic [PXW-1:0] pixset(int p0, int p1, int p2, int p3);
    logic [PXW-1:0] v = '0;
    if (p0 >= 0) v[0*NPIX + p0] = 1'b1;
    if (p1 >= 0) v[1*NPIX + p1] = 1'b1;
    if (p2 >= 0) v[2*NPIX + p2] = 1'b1;
    if (p3 >= 0) v[3*NPIX + p3] = 1'b1;
    return v;
  endfunction

  task automatic crossing(logic [PXW-1:0] p, string req);
    logic ef;
    logic [11:0] ew;
    logic [11:0] held;
    model(p, ef, ew);
    @(negedge clk);
    pix_in = p;
    xing_valid = 1'b1;
    @(negedge clk);
    xing_valid = 1'b0;
    pix_in = '0;
    @(negedge clk);
    chk({"R2 valid ", req}, 32'(trk_valid), 32'd1);
    chk({req, " found"}, 32'(trk_found), 32'(ef));
    chk({req, " word"},  32'(trk_word),  32'(ew));
    held = trk_word;
    @(negedge clk);
    chk("R2 single pulse", 32'(trk_valid), 32'd0);
    chk("R12 hold", 32'(trk_word), 32'(held));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R2 actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < NR; r++) begin
      m_vld[r] = 0; m_word[r] = '0;
      for (int l = 0; l < 4; l++) m_pix[r][l] = 0;
    end
    rst_n = 1'b0; xing_valid = 1'b0; pix_in = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_pix = '0; cfg_word = '0; cfg_vld = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 valid", 32'(trk_valid), 0);
    chk("R1 found", 32'(trk_found), 0);
    chk("R1 word",  32'(trk_word),  0);
    rst_n = 1'b1;
    @(negedge clk);
    crossing('1, "R1 empty table");

    // R3 full match
    load(4, 1, 2, 3, 4, 12'hA11, 1);
    crossing(pixset(1, 2, 3, 4), "R3 full");
    // R4 each layer missing in turn
    crossing(pixset(-1, 2, 3, 4), "R4 miss l0");
    crossing(pixset(1, -1, 3, 4), "R4 miss l1");
    crossing(pixset(1, 2, -1, 4), "R4 miss l2");
    crossing(pixset(1, 2, 3, -1), "R4 miss l3");
    // R5 two layers only
    crossing(pixset(1, 2, -1, -1), "R5 two");
    crossing(pixset(-1, -1, 3, 4), "R5 two b");
    // R6 full at higher index beats partial at lower
    load(1, 7, 8, 9, 10, 12'hB22, 1);
    load(9, 7, 8, 9, 11, 12'hC33, 1);
    crossing(pixset(7, 8, 9, 11), "R6 full beats part");
    // R7 identical roads: lowest index
    load(2, 5, 6, 7, 8, 12'hD44, 1);
    load(12, 5, 6, 7, 8, 12'hE55, 1);
    crossing(pixset(5, 6, 7, 8), "R7 lowest full");
    crossing(pixset(5, -1, 7, 8), "R7 lowest part");
    // R8 nothing fired
    crossing('0, "R8 none");
    // R9 invalid entry
    load(0, 20, 20, 20, 20, 12'hF66, 0);
    crossing(pixset(20, 20, 20, 20), "R9 invalid");
    // R10 overwrite entry 4
    load(4, 1, 2, 3, 5, 12'h777, 1);
    crossing(pixset(1, 2, 3, 4), "R10 old gone");
    crossing(pixset(1, 2, 3, 5), "R10 new");
    // R11 out-of-window index
    for (int r = 0; r < NR; r++) load(r, 0, 0, 0, 0, 12'h0, 0);
    load(3, 30, 1, 1, 1, 12'h388, 1);
    load(6, 25, 31, 1, 1, 12'h399, 1);
    crossing('1, "R11 out of window");

    // random tables and hits
    for (int it = 0; it < 400; it++) begin
      logic [PXW-1:0] p;
      if (it % 25 == 0) begin
        for (int r = 0; r < NR; r++)
          load(r, $urandom % 32, $urandom % 32, $urandom % 32, $urandom % 32,
               12'($urandom), ($urandom % 4) != 0);
      end
      p = PXW'({$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom}
               & {$urandom, $urandom, $urandom});
      begin
        int r = $urandom % NR;
        int drop = $urandom % 6;
        for (int l = 0; l < 4; l++)
          if (l != drop && m_pix[r][l] < NPIX) p[l*NPIX + m_pix[r][l]] = 1'b1;
      end
      crossing(p, "R6 R7 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule